// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits after the clock synthesizer and decides, per output, whether a clock toggles or sits at a fixed level. It has two groups of clocks. A bank of single-ended bus clocks plus a few optionally free-running bus clocks share one source. A set of differential host clock pairs shares a second source. Each group has its own active-low stop request, and each request is synchronized into its own clock domain before it has any effect.

The gating enable for each group changes only while the source clock already sits at the park level of that group. A stopping clock therefore ends on a whole pulse, and a restarting clock begins with a whole pulse. When stopped, the bus clocks rest low. The true leg of each host pair rests high and the complement leg rests low, so the pair always stays complementary.

One shared pin has two roles, chosen by a mode bit. In one role it is the bus-clock stop input, with its pull-up enabled. In the other role it is an open-drain system-reset output with its pull-up disabled, and the bus clocks cannot be stopped.

Top module: `clk_stop_gate`

## Requirements
- R1: With the mode bit at 1 and `pci_stop_n` held low, all `pci_o` outputs stop within SYNC_STAGES+1 bus-clock cycles and stay low.
- R2: A bit of `free_run` at 1 keeps the matching `pcif_o` output toggling while the bus stop is active. A bit at 0 makes that output stop low together with `pci_o`. Bit i of `free_run` controls bit i of `pcif_o`.
- R3: With `cpu_stop_n` held low, every `cpu_t_o` bit parks high and every `cpu_c_o` bit parks low, within SYNC_STAGES+1 host-clock cycles.
- R4: `stop_pin_mode` at 1 makes the shared pin the bus stop input, with `stop_pin_pu_en` at 1. At 0, `pci_stop_n` has no effect on any bus clock and `stop_pin_pu_en` is 0.
- R5: `srst_oe` follows `srst_req` only while `stop_pin_mode` is 0. While the mode bit is 1, `srst_oe` stays 0.
- R6: No output ever produces a runt. Every high pulse of `pci_o`/`pcif_o` lasts one full half period of `pci_clk`. Every low pulse of `cpu_t_o` and every high pulse of `cpu_c_o` lasts one full half period of `cpu_clk`.
- R7: After a stop request is released, the outputs return to following their source clock, starting on a whole pulse.
- R8: After reset, with both stop inputs high, every output follows its source clock: `pci_o` and `pcif_o` match `pci_clk`, `cpu_t_o` matches `cpu_clk`, and `cpu_c_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; enables come up running |
| pci_clk | input | 1 | Source clock for the bus clock group |
| cpu_clk | input | 1 | Source clock for the host clock pairs |
| pci_stop_n | input | 1 | Active-low bus clock stop request (shared pin, input role) |
| cpu_stop_n | input | 1 | Active-low host clock stop request |
| stop_pin_mode | input | 1 | 1: shared pin is the stop input; 0: shared pin is the reset output |
| free_run | input | N_FREE | Per-output exemption of `pcif_o` from the bus stop |
| srst_req | input | 1 | System reset request, driven onto the shared pin in mode 0 |
| pci_o | output | N_PCI | Gated bus clocks, park low |
| pcif_o | output | N_FREE | Gated bus clocks that can be made free-running |
| cpu_t_o | output | N_CPU | True legs of the host pairs, park high |
| cpu_c_o | output | N_CPU | Complement legs of the host pairs, park low |
| srst_oe | output | 1 | Open-drain pull-low enable for the shared pin |
| stop_pin_pu_en | output | 1 | Pull-up enable for the shared pin |

## Verification
The bench uses the default parameters: six bus clocks, two exemptible clocks, two host pairs and a two-stage synchronizer. With two `free_run` bits, the mixed settings 01 and 10 can be driven, which shows that each bit exempts only its own output. The short synchronizer lets each stop or release settle within a few cycles, so pulse widths can be measured on every edge across many stop and release transitions. The bus and host clocks run at a 3:1 ratio. This ratio lets one sample point check a bus high phase and a host low phase in the same instant.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_PCI       = 6,
  parameter int N_FREE      = 2,
  parameter int N_CPU       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              pci_clk,
  input  logic              cpu_clk,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic              stop_pin_mode,
  input  logic [N_FREE-1:0] free_run,
  input  logic              srst_req,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_FREE-1:0] pcif_o,
  output logic [N_CPU-1:0]  cpu_t_o,
  output logic [N_CPU-1:0]  cpu_c_o,
  output logic              srst_oe,
  output logic              stop_pin_pu_en
);

  localparam int AGE_MAX = SYNC_STAGES + 2;
  localparam int AGE_W   = $clog2(AGE_MAX + 1) + 1;

  logic                   pci_req_n;
  logic [SYNC_STAGES-1:0] pci_sync, cpu_sync;
  logic                   pci_run, cpu_run;
  logic                   pci_en;
  logic [N_FREE-1:0]      pcif_en;

  // In reset-output mode the shared pin carries no stop request.
  assign pci_req_n = ~stop_pin_mode | pci_stop_n;

  always_ff @(posedge pci_clk or negedge rst_n)
    if (!rst_n) pci_sync <= '1;
    else        pci_sync <= {pci_sync[SYNC_STAGES-2:0], pci_req_n};

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_sync <= '1;
    else        cpu_sync <= {cpu_sync[SYNC_STAGES-2:0], cpu_stop_n};

  assign pci_run = pci_sync[SYNC_STAGES-1];
  assign cpu_run = cpu_sync[SYNC_STAGES-1];

  // Bus clocks park low: the enable changes only on the falling edge.
  always_ff @(negedge pci_clk or negedge rst_n)
    if (!rst_n) begin
      pci_en  <= 1'b1;
      pcif_en <= '1;
    end else begin
      pci_en  <= pci_run;
      pcif_en <= free_run | {N_FREE{pci_run}};
    end

  assign pci_o  = {N_PCI{pci_clk & pci_en}};
  assign pcif_o = {N_FREE{pci_clk}} & pcif_en;

  // Host pairs park true-high / complement-low: the enable changes on the
  // rising edge, when both legs already sit at their park levels.
  assign cpu_t_o = {N_CPU{cpu_clk | ~cpu_run}};
  assign cpu_c_o = {N_CPU{~cpu_clk & cpu_run}};

  assign srst_oe        = ~stop_pin_mode & srst_req;
  assign stop_pin_pu_en = stop_pin_mode;

  // ---------------------------------------------------------------- checks
  logic [AGE_W-1:0] pci_age, cpu_age;

  always_ff @(posedge pci_clk or negedge rst_n)
    if (!rst_n)                pci_age <= '0;
    else if (pci_age < AGE_MAX) pci_age <= pci_age + 1'b1;

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n)                cpu_age <= '0;
    else if (cpu_age < AGE_MAX) cpu_age <= cpu_age + 1'b1;

  a_r1_pci_parked: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (pci_age > 0 && !$past(pci_run)) |-> pci_o == '0);

  a_r7_pci_resumed: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (pci_age > 0 && $past(pci_run)) |-> pci_o == '1);

  for (genvar i = 0; i < N_FREE; i++) begin : g_free_chk
    a_r2_free_toggles: assert property (@(negedge pci_clk) disable iff (!rst_n)
      (pci_age > 0 && $past(free_run[i])) |-> pcif_o[i]);
  end

  a_r4_mode0_no_stop: assert property (@(posedge pci_clk) disable iff (!rst_n)
    !stop_pin_mode |=> pci_sync[0]);

  a_r3_cpu_parked: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (cpu_age > SYNC_STAGES && !$past(cpu_stop_n, SYNC_STAGES))
      |-> (cpu_t_o == '1 && cpu_c_o == '0));

  a_r7_cpu_resumed: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (cpu_age > SYNC_STAGES && $past(cpu_stop_n, SYNC_STAGES))
      |-> (cpu_t_o == '0 && cpu_c_o == '1));

  a_r5_oe_mode_only: assert property (@(posedge pci_clk) disable iff (!rst_n)
    stop_pin_mode |-> (!srst_oe && stop_pin_pu_en));

endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;
  localparam int PCI_PERIOD = 30;
  localparam int CPU_PERIOD = 10;

  logic       rst_n = 0, pci_clk = 0, cpu_clk = 0;
  logic       pci_stop_n = 1, cpu_stop_n = 1, stop_pin_mode = 1, srst_req = 0;
  logic [1:0] free_run = 2'b00;
  logic [5:0] pci_o;
  logic [1:0] pcif_o, cpu_t_o, cpu_c_o;
  logic       srst_oe, stop_pin_pu_en;

  int n_tests = 0, n_fail = 0, n_pushed = 0, n_checked = 0;
  bit mon_en = 0;

  typedef struct {
    string      req;
    logic [5:0] pci;
    logic [1:0] pcif, cput, cpuc;
    logic       oe, pu;
  } exp_t;
  exp_t q[$];

  clk_stop_gate u_dut (
    .rst_n(rst_n), .pci_clk(pci_clk), .cpu_clk(cpu_clk),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .stop_pin_mode(stop_pin_mode), .free_run(free_run), .srst_req(srst_req),
    .pci_o(pci_o), .pcif_o(pcif_o), .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o),
    .srst_oe(srst_oe), .stop_pin_pu_en(stop_pin_pu_en));

  initial forever #(PCI_PERIOD/2) pci_clk = ~pci_clk;
  initial forever #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;

  // Monitor: sample a bus high phase, which is also a host low phase.
  initial forever begin
    exp_t e;
    wait (q.size() > 0);
    e = q.pop_front();
    @(posedge pci_clk); #7;
    n_tests++;
    if (pci_o !== e.pci || pcif_o !== e.pcif || cpu_t_o !== e.cput ||
        cpu_c_o !== e.cpuc || srst_oe !== e.oe || stop_pin_pu_en !== e.pu) begin
      n_fail++;
      $display("FAIL %s: actual pci=%h f=%b t=%b c=%b oe=%b pu=%b expected pci=%h f=%b t=%b c=%b oe=%b pu=%b",
        e.req, pci_o, pcif_o, cpu_t_o, cpu_c_o, srst_oe, stop_pin_pu_en,
        e.pci, e.pcif, e.cput, e.cpuc, e.oe, e.pu);
    end
    n_checked++;
  end

  // R6 pulse-width monitors
  task automatic width_chk(input string what, input longint w, input longint want);
    n_tests++;
    if (w != want) begin
      n_fail++;
      $display("FAIL R6 %s pulse: actual %0d expected %0d", what, w, want);
    end
  endtask

  longint t_p = -1, t_f = -1, t_t = -1, t_c = -1;
  always @(posedge pci_o[0])  t_p = mon_en ? $time : -1;
  always @(negedge pci_o[0])  if (mon_en && t_p >= 0) width_chk("pci", $time - t_p, PCI_PERIOD/2);
  always @(posedge pcif_o[1]) t_f = mon_en ? $time : -1;
  always @(negedge pcif_o[1]) if (mon_en && t_f >= 0) width_chk("pcif", $time - t_f, PCI_PERIOD/2);
  always @(negedge cpu_t_o[0]) t_t = mon_en ? $time : -1;
  always @(posedge cpu_t_o[0]) if (mon_en && t_t >= 0) width_chk("cpu_t low", $time - t_t, CPU_PERIOD/2);
  always @(posedge cpu_c_o[1]) t_c = mon_en ? $time : -1;
  always @(negedge cpu_c_o[1]) if (mon_en && t_c >= 0) width_chk("cpu_c high", $time - t_c, CPU_PERIOD/2);

  // Driver: apply inputs away from edges, let them settle, push the expectation.
  task automatic step(input string req, input logic ps, input logic cs, input logic md,
                      input logic [1:0] fr, input logic sr,
                      input logic [5:0] pci, input logic [1:0] pcif,
                      input logic [1:0] cput, input logic [1:0] cpuc,
                      input logic oe, input logic pu);
    exp_t e;
    @(posedge pci_clk); #3;
    pci_stop_n = ps; cpu_stop_n = cs; stop_pin_mode = md; free_run = fr; srst_req = sr;
    repeat (6) @(posedge pci_clk);
    e.req = req; e.pci = pci; e.pcif = pcif; e.cput = cput; e.cpuc = cpuc; e.oe = oe; e.pu = pu;
    q.push_back(e);
    n_pushed++;
    wait (n_checked == n_pushed);
  endtask

  bit done = 0;
  initial begin
    #(PCI_PERIOD * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #103 rst_n = 1;
    #20 mon_en = 1;
    //   req  ps cs md fr     sr  pci    pcif   cput   cpuc   oe pu
    step("R8", 1, 1, 1, 2'b00, 0, 6'h3F, 2'b11, 2'b00, 2'b11, 0, 1);
    step("R1", 0, 1, 1, 2'b00, 0, 6'h00, 2'b00, 2'b00, 2'b11, 0, 1);
    step("R2", 0, 1, 1, 2'b01, 0, 6'h00, 2'b01, 2'b00, 2'b11, 0, 1);
    step("R2", 0, 1, 1, 2'b10, 0, 6'h00, 2'b10, 2'b00, 2'b11, 0, 1);
    step("R3", 0, 0, 1, 2'b10, 0, 6'h00, 2'b10, 2'b11, 2'b00, 0, 1);
    step("R7", 1, 0, 1, 2'b10, 0, 6'h3F, 2'b11, 2'b11, 2'b00, 0, 1);
    step("R7", 1, 1, 1, 2'b00, 0, 6'h3F, 2'b11, 2'b00, 2'b11, 0, 1);
    step("R4", 0, 1, 0, 2'b00, 0, 6'h3F, 2'b11, 2'b00, 2'b11, 0, 0);
    step("R5", 0, 1, 0, 2'b00, 1, 6'h3F, 2'b11, 2'b00, 2'b11, 1, 0);
    step("R5", 1, 1, 1, 2'b00, 1, 6'h3F, 2'b11, 2'b00, 2'b11, 0, 1);
    step("R4", 0, 1, 1, 2'b00, 0, 6'h00, 2'b00, 2'b00, 2'b11, 0, 1);
    step("R3", 0, 0, 1, 2'b11, 0, 6'h00, 2'b11, 2'b11, 2'b00, 0, 1);
    step("R6", 1, 1, 1, 2'b00, 0, 6'h3F, 2'b11, 2'b00, 2'b11, 0, 1);
    repeat (4) @(posedge pci_clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule